// File: doc/BRIEF.md
# Key-Protected Watchdog Counter

This block is a watchdog timer with a guarded control register. Software writes a 32-bit word on the bus clock. A write takes effect only when the word, XOR-ed with a stored key, leaves bits 31 to 3 all zero. The three low bits of that XOR result then become the new control state: enable, counter reset and pause. Any other write changes nothing. The control state reads back with the key field forced to zero.

The control bits cross into a separate safe clock domain through a two-stage synchronizer. In that domain they drive a prescale counter and a timer counter. The prescale counter runs from zero up to a programmable limit and then wraps. Each wrap advances the timer counter by one. When the timer counter reaches a programmable match value, the block gives a single-cycle timeout pulse and the timer stops there until a counter reset is written. While the pause bit is set, a high debug-acknowledge input freezes both counters.

The write port is a plain strobe with no handshake. It accepts a word in every bus cycle, so it never applies back-pressure. Every other pin is plain control or status.

Top module: `wdk_watchdog`

## Requirements
- R1: With the default key 0x251D_8950, a write of 0x251D_8951 sets the enable bit. After the write, rd_data reads 0x0000_0001.
- R2: A write of 0x251D_8952 sets the counter-reset bit and clears enable. After the write, rd_data reads 0x0000_0002.
- R3: A write whose bits 31 to 3 differ from key bits 31 to 3 is ignored. rd_data and the counters are unchanged by it.
- R4: An accepted write loads control bits 2:0 from (wr_data XOR key): bit 0 is enable, bit 1 is reset and bit 2 is pause. For example, 0x251D_8955 sets enable and pause.
- R5: rd_data bits 31 to 3 always read zero, and rd_data bits 2:0 return the control state.
- R6: While the reset bit is active in the safe domain, pre_cnt and tmr_cnt are zero, even if enable is also set.
- R7: While enable is clear, pre_cnt and tmr_cnt hold their values. After enable is set they advance.
- R8: The prescale counter steps 0, 1, …, pre_limit and then returns to 0. Each return to 0 increments tmr_cnt by exactly one.
- R9: When tmr_cnt reaches match_val, timeout is high for exactly one safe-clock cycle while tmr_cnt equals match_val. tmr_cnt then holds at match_val until a counter reset.
- R10: With pause set and dbg_ack high, both counters hold their values. A high dbg_ack has no effect while pause is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Active-low async reset, bus domain |
| wr_en | input | 1 | Control-register write strobe |
| wr_data | input | 32 | Write word (key XOR control bits) |
| rd_data | output | 32 | Control readback, key field zero |
| safe_clk | input | 1 | Safe clock for the counters |
| safe_rst_n | input | 1 | Active-low async reset, safe domain |
| dbg_ack | input | 1 | Debug acknowledge, safe domain |
| pre_limit | input | PRE_W | Prescale wrap value |
| match_val | input | TC_W | Timer value that raises timeout |
| pre_cnt | output | PRE_W | Prescale counter value |
| tmr_cnt | output | TC_W | Timer counter value |
| timeout | output | 1 | Single-cycle pulse when the match value is reached |

## Verification
The bench builds the block with PRE_W=4 and TC_W=8, drives pre_limit=3 and match_val=40, and keeps the default key. With these values a full run from zero to the timeout pulse takes about 160 safe cycles. That is short enough to follow every prescale wrap and timer step one cycle at a time, and then to see the counter halt at the match value. The safe clock runs at a period unrelated to the bus clock, so each control change has to cross the synchronizer before the counters respond to it.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef struct packed {
    logic pause;
    logic rst;
    logic en;
  } wdk_ctrl_t;
  localparam int CTRL_W = 3;
endpackage

// File: rtl/wdk_keygate.sv
module wdk_keygate
  import wdk_pkg::*;
#(
  parameter logic [31:0] KEY = 32'h251D_8950
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output wdk_ctrl_t   ctrl,
  output logic [31:0] rd_data
);
  logic [31:0] diff;
  logic        hit;
  wdk_ctrl_t   ctrl_q;

  assign diff = wr_data ^ KEY;
  assign hit  = wr_en && (diff[31:CTRL_W] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ctrl_q <= '0;
    else if (hit) ctrl_q <= wdk_ctrl_t'(diff[CTRL_W-1:0]);
  end

  assign ctrl    = ctrl_q;
  assign rd_data = {{(32-CTRL_W){1'b0}}, ctrl_q};

  // R3: a word with a wrong key field leaves the control state alone
  a_r3_bad_word_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[31:CTRL_W] != KEY[31:CTRL_W])) |=> $stable(ctrl_q));
  // R4: an accepted word loads the XOR difference
  a_r4_loads_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[31:CTRL_W] == KEY[31:CTRL_W]))
      |=> (ctrl_q == $past(wr_data[CTRL_W-1:0] ^ KEY[CTRL_W-1:0])));
endmodule

// File: rtl/wdk_sync.sv
module wdk_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wdk_count.sv
module wdk_count
  import wdk_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int TC_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdk_ctrl_t        ctrl,
  input  logic             dbg_ack,
  input  logic [PRE_W-1:0] limit,
  input  logic [TC_W-1:0]  match,
  output logic [PRE_W-1:0] pre,
  output logic [TC_W-1:0]  tc,
  output logic             tmo
);
  logic             frozen, at_match, run;
  logic [TC_W-1:0]  tc_inc;

  assign frozen   = ctrl.pause && dbg_ack;
  assign at_match = (tc == match);
  assign run      = ctrl.en && !frozen && !at_match;
  assign tc_inc   = tc + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      tc  <= '0;
      tmo <= 1'b0;
    end else if (ctrl.rst) begin
      pre <= '0;
      tc  <= '0;
      tmo <= 1'b0;
    end else begin
      tmo <= 1'b0;
      if (run) begin
        if (pre >= limit) begin
          pre <= '0;
          tc  <= tc_inc;
          tmo <= (tc_inc == match);
        end else begin
          pre <= pre + 1'b1;
        end
      end
    end
  end

  // R6: a held reset bit keeps both counters at zero
  a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.rst |=> (tc == '0 && pre == '0));
  // R7: no enable, no movement
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.rst && !ctrl.en) |=> ($stable(tc) && $stable(pre)));
  // R10: pause plus debug acknowledge freezes both counters
  a_r10_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.rst && ctrl.pause && dbg_ack) |=> ($stable(tc) && $stable(pre)));
  // R9: the timeout pulse lasts one cycle and coincides with the match value
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !tmo);
  a_r9_pulse_at_match: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && $stable(match)) |-> (tc == match));
endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog
  import wdk_pkg::*;
#(
  parameter logic [31:0] KEY         = 32'h251D_8950,
  parameter int          PRE_W       = 8,
  parameter int          TC_W        = 16,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             bus_clk,
  input  logic             bus_rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             safe_clk,
  input  logic             safe_rst_n,
  input  logic             dbg_ack,
  input  logic [PRE_W-1:0] pre_limit,
  input  logic [TC_W-1:0]  match_val,
  output logic [PRE_W-1:0] pre_cnt,
  output logic [TC_W-1:0]  tmr_cnt,
  output logic             timeout
);
  wdk_ctrl_t          ctrl_bus;
  logic [CTRL_W-1:0]  ctrl_sync;

  wdk_keygate #(.KEY(KEY)) u_gate (
    .clk     (bus_clk),
    .rst_n   (bus_rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl_bus),
    .rd_data (rd_data)
  );

  wdk_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (safe_clk),
    .rst_n (safe_rst_n),
    .d     (ctrl_bus),
    .q     (ctrl_sync)
  );

  wdk_count #(.PRE_W(PRE_W), .TC_W(TC_W)) u_cnt (
    .clk     (safe_clk),
    .rst_n   (safe_rst_n),
    .ctrl    (wdk_ctrl_t'(ctrl_sync)),
    .dbg_ack (dbg_ack),
    .limit   (pre_limit),
    .match   (match_val),
    .pre     (pre_cnt),
    .tc      (tmr_cnt),
    .tmo     (timeout)
  );
endmodule

// File: tb/sim_wdk_watchdog.sv
module sim_wdk_watchdog;
  localparam int          PRE_W = 4;
  localparam int          TC_W  = 8;
  localparam logic [31:0] KEY   = 32'h251D_8950;
  localparam logic [PRE_W-1:0] LIMIT = 4'd3;
  localparam logic [TC_W-1:0]  MATCH = 8'd40;

  logic clk = 0, sclk = 0;
  logic bus_rst_n = 0, safe_rst_n = 0;
  logic wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic dbg_ack = 0;
  logic [PRE_W-1:0] pre_cnt;
  logic [TC_W-1:0]  tmr_cnt;
  logic timeout;
  int total = 0, bad = 0;

  always #5 clk = ~clk;
  always #7 sclk = ~sclk;

  wdk_watchdog #(.KEY(KEY), .PRE_W(PRE_W), .TC_W(TC_W)) u0 (
    .bus_clk(clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .safe_clk(sclk), .safe_rst_n(safe_rst_n),
    .dbg_ack(dbg_ack), .pre_limit(LIMIT), .match_val(MATCH),
    .pre_cnt(pre_cnt), .tmr_cnt(tmr_cnt), .timeout(timeout)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic swait(input int n);
    repeat (n) @(negedge sclk);
  endtask

  task automatic t_reset;
    swait(1);
    chk(rd_data == 32'h0, "R5 reset readback", rd_data, 0);
    chk(tmr_cnt == 0 && pre_cnt == 0, "R6 counters at reset", {tmr_cnt, pre_cnt}, 0);
    chk(timeout == 0, "R9 no timeout at reset", timeout, 0);
  endtask

  task automatic t_bad_writes;
    bus_wr(32'h251D_8959);
    chk(rd_data == 0, "R3 bit3 differs", rd_data, 0);
    bus_wr(32'h1234_5671);
    chk(rd_data == 0, "R3 random word", rd_data, 0);
    bus_wr(32'hA51D_8951);
    chk(rd_data == 0, "R3 top bit differs", rd_data, 0);
    swait(8);
    chk(tmr_cnt == 0 && pre_cnt == 0, "R3 counters idle", {tmr_cnt, pre_cnt}, 0);
  endtask

  task automatic t_start;
    int pulses = 0;
    bit seq_ok = 1, pulse_ok = 1;
    logic [PRE_W-1:0] pp;
    logic [TC_W-1:0]  pt;
    bus_wr(KEY ^ 32'h1);
    chk(rd_data == 32'h1, "R1 start word", rd_data, 1);
    pp = pre_cnt; pt = tmr_cnt;
    for (int i = 0; i < 250; i++) begin
      @(negedge sclk);
      if (timeout) begin
        pulses++;
        if (tmr_cnt != MATCH) pulse_ok = 0;
      end
      if (tmr_cnt != pt) begin
        if (!(pp == LIMIT && pre_cnt == 0 && tmr_cnt == TC_W'(pt + 1))) seq_ok = 0;
      end else if (pre_cnt != pp) begin
        if (pre_cnt != PRE_W'(pp + 1)) seq_ok = 0;
      end
      pp = pre_cnt; pt = tmr_cnt;
    end
    chk(seq_ok, "R8 prescale wrap sequence", seq_ok, 1);
    chk(pulses == 1, "R9 single pulse", pulses, 1);
    chk(pulse_ok, "R9 pulse at match", pulse_ok, 1);
    chk(tmr_cnt == MATCH, "R9 hold at match", tmr_cnt, MATCH);
  endtask

  task automatic t_reset_hold;
    bus_wr(KEY ^ 32'h2);
    chk(rd_data == 32'h2, "R2 reset word", rd_data, 2);
    swait(6);
    chk(tmr_cnt == 0 && pre_cnt == 0, "R6 cleared", {tmr_cnt, pre_cnt}, 0);
    bus_wr(KEY ^ 32'h3);
    chk(rd_data == 32'h3, "R4 enable plus reset", rd_data, 3);
    swait(12);
    chk(tmr_cnt == 0 && pre_cnt == 0, "R6 held with enable", {tmr_cnt, pre_cnt}, 0);
    bus_wr(KEY ^ 32'h1);
    swait(12);
    chk(tmr_cnt != 0 || pre_cnt != 0, "R7 runs after enable", {tmr_cnt, pre_cnt}, 1);
  endtask

  task automatic t_idle_hold;
    logic [PRE_W+TC_W-1:0] snap;
    bus_wr(KEY);
    chk(rd_data == 32'h0, "R4 all bits clear", rd_data, 0);
    swait(6);
    snap = {tmr_cnt, pre_cnt};
    swait(12);
    chk({tmr_cnt, pre_cnt} == snap, "R7 hold when disabled", {tmr_cnt, pre_cnt}, snap);
  endtask

  task automatic t_pause;
    logic [PRE_W+TC_W-1:0] snap;
    bus_wr(KEY ^ 32'h2);
    swait(6);
    bus_wr(KEY ^ 32'h1);
    swait(6);
    @(negedge sclk); dbg_ack = 1;
    snap = {tmr_cnt, pre_cnt};
    swait(3);
    chk({tmr_cnt, pre_cnt} != snap, "R10 dbg_ack without pause", {tmr_cnt, pre_cnt}, snap);
    bus_wr(KEY ^ 32'h5);
    chk(rd_data == 32'h5, "R4 enable plus pause", rd_data, 5);
    swait(6);
    snap = {tmr_cnt, pre_cnt};
    swait(12);
    chk({tmr_cnt, pre_cnt} == snap, "R10 frozen in debug", {tmr_cnt, pre_cnt}, snap);
    @(negedge sclk); dbg_ack = 0;
    swait(4);
    chk({tmr_cnt, pre_cnt} != snap, "R10 resumes after debug", {tmr_cnt, pre_cnt}, snap);
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    bus_rst_n = 1;
    safe_rst_n = 1;
    t_reset;
    t_bad_writes;
    t_start;
    t_reset_hold;
    t_idle_hold;
    t_pause;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule